// File: doc/BRIEF.md
# Programmable Three-Port Parallel Interface

A register block sitting between a processor bus and three 8-bit parallel ports (A, B and C). The processor reaches four locations through two address bits: one for each port and one for a control word. Port C is handled as two 4-bit halves, so the block manages four direction groups: A, B, C-high and C-low. Only the basic mode is implemented. Each group is independently an input or an output. Outputs come from write latches. Inputs are sampled straight from the pins when they are read.

The bus is synchronous to `clk_i`. A write takes effect on the clock edge while it is qualified. Read data is combinational, and the bus output-enable marks when it is valid. Pins are split into an input, an output and a per-bit output-enable. A pin that is not enabled is left to its default external level, which the system treats as logic 1.

Top module: `pio_three_port`

## Requirements
- R1: After reset (`rst_ni` low) the control word reads back as 8'h9B and every pin output-enable is 0.
- R2: Address 0 selects port A, 1 port B, 2 port C and 3 the control word, for both reads and writes.
- R3: A write happens only on a clock edge where `cs_ni`=0, `wr_ni`=0 and `rd_ni`=1. Any other combination leaves the latches and the control word unchanged.
- R4: `data_oe_o` is 1 exactly when `cs_ni`=0, `rd_ni`=0 and `wr_ni`=1. Otherwise the bus is released.
- R5: A control write with data bit 7 = 1 is a mode word. Bit 4 sets the direction of A, bit 1 sets B, bit 3 sets C[7:4] and bit 0 sets C[3:0], where 1 = input and 0 = output. The output-enables of each group follow on the next cycle.
- R6: A mode word clears every port output latch to zero.
- R7: A control read returns bit 7 as 1 and bits 6:0 as last written by a mode word, including the mode field bits 6:5 and bit 2.
- R8: A port read returns the output latch for an output group and the live pin value for an input group.
- R9: A control write with data bit 7 = 0 changes neither the control word nor any latch.
- R10: The two halves of port C are independent. A read of port C combines each half's own source, and a write to port C loads both half-latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Location select |
| data_i | input | 8 | Write data from the bus |
| data_o | output | 8 | Read data to the bus |
| data_oe_o | output | 1 | Bus drive enable |
| pa_i | input | 8 | Port A pin levels |
| pa_o | output | 8 | Port A output latch |
| pa_oe_o | output | 8 | Port A pin drive enables |
| pb_i | input | 8 | Port B pin levels |
| pb_o | output | 8 | Port B output latch |
| pb_oe_o | output | 8 | Port B pin drive enables |
| pc_i | input | 8 | Port C pin levels |
| pc_o | output | 8 | Port C output latch |
| pc_oe_o | output | 8 | Port C pin drive enables |

## Verification
A corrupted control word shows up at once on the pin output-enables of the affected group, one cycle after the write. It also appears on the next control read. A latch that is wrongly cleared or wrongly loaded appears on the pin outputs in the cycle after the offending edge, and on a read of that port if the port is an output. A direction bit that is swapped between groups is caught by mixed-direction mode words in which the two halves of port C, and ports A and B, differ.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned NW = DW / 2;
  localparam logic [DW-1:0] CTRL_RST = 8'h9B;
  localparam int unsigned MODE_FLAG_BIT = 7;
  localparam int unsigned DIR_A_BIT  = 4;
  localparam int unsigned DIR_CH_BIT = 3;
  localparam int unsigned DIR_B_BIT  = 1;
  localparam int unsigned DIR_CL_BIT = 0;
  typedef enum logic [1:0] {
    SEL_A = 2'd0, SEL_B = 2'd1, SEL_C = 2'd2, SEL_CTRL = 2'd3
  } sel_e;
endpackage

// File: rtl/pio_bus_dec.sv
module pio_bus_dec (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       rd_ni,
  input  logic       wr_ni,
  input  logic [1:0] addr_i,
  output logic [3:0] wr_sel_o,
  output logic       rd_act_o
);
  import pio_pkg::*;
  logic wr_act;
  assign wr_act   = !cs_ni && !wr_ni && rd_ni;
  assign rd_act_o = !cs_ni && !rd_ni && wr_ni;

  always_comb begin
    wr_sel_o = '0;
    if (wr_act) wr_sel_o[addr_i] = 1'b1;
  end

  // R2
  wr_sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel_o));
  // R4
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_act_o |-> (wr_sel_o == '0));
endmodule

// File: rtl/pio_ctrl_reg.sv
module pio_ctrl_reg
  import pio_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctrl_o,
  output logic          mode_wr_o,
  output logic [3:0]    dir_in_o
);
  logic [DW-1:0] ctrl_q;
  assign mode_wr_o = wr_i && wdata_i[MODE_FLAG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= CTRL_RST;
    else if (mode_wr_o) ctrl_q <= wdata_i;
  end

  assign ctrl_o   = ctrl_q | (DW'(1) << MODE_FLAG_BIT);
  // order: A, B, C-high, C-low
  assign dir_in_o = {ctrl_q[DIR_A_BIT], ctrl_q[DIR_B_BIT],
                     ctrl_q[DIR_CH_BIT], ctrl_q[DIR_CL_BIT]};

  // R9
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i[MODE_FLAG_BIT]) |=> $stable(ctrl_q));
endmodule

// File: rtl/pio_port_slice.sv
module pio_port_slice #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         dir_in_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     latch_q <= '0;
    else if (clr_i)  latch_q <= '0;
    else if (wr_i)   latch_q <= wdata_i;
  end

  assign pin_o    = latch_q;
  assign pin_oe_o = {W{!dir_in_i}};
  assign rdata_o  = dir_in_i ? pin_i : latch_q;

  // R6
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pin_o == '0));
  // R3
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !clr_i) |=> $stable(pin_o));
endmodule

// File: rtl/pio_three_port.sv
module pio_three_port
  import pio_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  input  logic [DW-1:0] pa_i,
  output logic [DW-1:0] pa_o,
  output logic [DW-1:0] pa_oe_o,
  input  logic [DW-1:0] pb_i,
  output logic [DW-1:0] pb_o,
  output logic [DW-1:0] pb_oe_o,
  input  logic [DW-1:0] pc_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] pc_oe_o
);
  logic [3:0]    wr_sel;
  logic          rd_act;
  logic [DW-1:0] ctrl;
  logic          mode_wr;
  logic [3:0]    dir_in;
  logic [DW-1:0] rd_a, rd_b, rd_c;

  pio_bus_dec u_dec (
    .clk_i, .rst_ni, .cs_ni, .rd_ni, .wr_ni, .addr_i,
    .wr_sel_o(wr_sel), .rd_act_o(rd_act)
  );

  pio_ctrl_reg u_ctrl (
    .clk_i, .rst_ni, .wr_i(wr_sel[SEL_CTRL]), .wdata_i(data_i),
    .ctrl_o(ctrl), .mode_wr_o(mode_wr), .dir_in_o(dir_in)
  );

  pio_port_slice #(.W(DW)) u_pa (
    .clk_i, .rst_ni, .wr_i(wr_sel[SEL_A]), .clr_i(mode_wr), .wdata_i(data_i),
    .dir_in_i(dir_in[3]), .pin_i(pa_i), .pin_o(pa_o), .pin_oe_o(pa_oe_o),
    .rdata_o(rd_a)
  );

  pio_port_slice #(.W(DW)) u_pb (
    .clk_i, .rst_ni, .wr_i(wr_sel[SEL_B]), .clr_i(mode_wr), .wdata_i(data_i),
    .dir_in_i(dir_in[2]), .pin_i(pb_i), .pin_o(pb_o), .pin_oe_o(pb_oe_o),
    .rdata_o(rd_b)
  );

  // port C halves: g=1 upper (dir_in[1]), g=0 lower (dir_in[0])
  for (genvar g = 0; g < 2; g++) begin : g_pc
    pio_port_slice #(.W(NW)) u_half (
      .clk_i, .rst_ni, .wr_i(wr_sel[SEL_C]), .clr_i(mode_wr),
      .wdata_i(data_i[g*NW +: NW]), .dir_in_i(dir_in[g]),
      .pin_i(pc_i[g*NW +: NW]), .pin_o(pc_o[g*NW +: NW]),
      .pin_oe_o(pc_oe_o[g*NW +: NW]), .rdata_o(rd_c[g*NW +: NW])
    );
  end

  always_comb begin
    unique case (sel_e'(addr_i))
      SEL_A:   data_o = rd_a;
      SEL_B:   data_o = rd_b;
      SEL_C:   data_o = rd_c;
      default: data_o = ctrl;
    endcase
  end
  assign data_oe_o = rd_act;

  // R4
  bus_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || rd_ni) |-> !data_oe_o);
  // R7
  ctrl_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && addr_i == 2'd3) |-> data_o[MODE_FLAG_BIT]);
  // R5
  dir_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr |=> (pa_oe_o == {DW{!$past(data_i[DIR_A_BIT])}}));
  // R5
  dir_cl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr |=> (pc_oe_o[NW-1:0] == {NW{!$past(data_i[DIR_CL_BIT])}}));
endmodule

// File: tb/pio_three_port_bench.sv
`timescale 1ns/100ps
module pio_three_port_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout, pa_o, pa_oe, pb_o, pb_oe, pc_o, pc_oe;
  logic       dout_oe;
  logic [7:0] ext_a = 8'hFF, ext_b = 8'hFF, ext_c = 8'hFF;
  logic [7:0] pa_pin, pb_pin, pc_pin;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  // undriven pins sit at the external level (default 1)
  assign pa_pin = (pa_oe & pa_o) | (~pa_oe & ext_a);
  assign pb_pin = (pb_oe & pb_o) | (~pb_oe & ext_b);
  assign pc_pin = (pc_oe & pc_o) | (~pc_oe & ext_c);

  pio_three_port u_pio_three_port (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(dout_oe),
    .pa_i(pa_pin), .pa_o(pa_o), .pa_oe_o(pa_oe),
    .pb_i(pb_pin), .pb_o(pb_o), .pb_oe_o(pb_oe),
    .pc_i(pc_pin), .pc_o(pc_o), .pc_oe_o(pc_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d,
                        input logic cs = 1'b0, input logic rd = 1'b1);
    @(negedge clk);
    addr = a; din = d; cs_n = cs; rd_n = rd; wr_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
    #1;
    d = dout; oe = dout_oe;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic t_reset;
    logic [7:0] d; logic oe;
    bus_rd(2'd3, d, oe);
    check("R1 ctrl reset", d, 8'h9B);
    check("R4 oe on read", {7'd0, oe}, 8'h01);
    check("R1 oe a/b", pa_oe | pb_oe, 8'h00);
    check("R1 oe c", pc_oe, 8'h00);
    bus_rd(2'd0, d, oe);
    check("R8 input read undriven A", d, 8'hFF);
  endtask

  task automatic t_all_out;
    logic [7:0] d; logic oe;
    bus_wr(2'd3, 8'h80);
    check("R5 A oe", pa_oe, 8'hFF);
    check("R5 B oe", pb_oe, 8'hFF);
    check("R5 C oe", pc_oe, 8'hFF);
    bus_wr(2'd0, 8'h5A); bus_wr(2'd1, 8'hC3); bus_wr(2'd2, 8'h96);
    check("R2 pin A", pa_o, 8'h5A);
    check("R2 pin B", pb_o, 8'hC3);
    check("R10 pin C", pc_o, 8'h96);
    bus_rd(2'd0, d, oe); check("R8 read A latch", d, 8'h5A);
    bus_rd(2'd1, d, oe); check("R2 read B latch", d, 8'hC3);
    bus_rd(2'd2, d, oe); check("R2 read C latch", d, 8'h96);
    bus_rd(2'd3, d, oe); check("R7 ctrl read", d, 8'h80);
  endtask

  task automatic t_clear;
    bus_wr(2'd3, 8'h80);
    check("R6 A cleared", pa_o, 8'h00);
    check("R6 B cleared", pb_o, 8'h00);
    check("R6 C cleared", pc_o, 8'h00);
  endtask

  task automatic t_mixed;
    logic [7:0] d; logic oe;
    bus_wr(2'd1, 8'h77); bus_wr(2'd2, 8'hFF);
    bus_wr(2'd3, 8'h8A); // A out, B in, C-high in, C-low out
    check("R6 latch B cleared", pb_o, 8'h00);
    check("R5 A oe", pa_oe, 8'hFF);
    check("R5 B oe", pb_oe, 8'h00);
    check("R5 C oe", pc_oe, 8'h0F);
    ext_b = 8'h3C; ext_c = 8'hE7;
    bus_wr(2'd2, 8'h05);
    check("R10 C latch", pc_o, 8'h05);
    bus_rd(2'd2, d, oe); check("R10 C mixed read", d, 8'hE5);
    bus_rd(2'd1, d, oe); check("R8 B pin read", d, 8'h3C);
    bus_wr(2'd3, 8'h81); // only C-low in
    ext_c = 8'h9A;
    bus_wr(2'd2, 8'hB0);
    bus_rd(2'd2, d, oe); check("R10 C swapped read", d, 8'hBA);
    check("R5 C oe swapped", pc_oe, 8'hF0);
  endtask

  task automatic t_ignored;
    logic [7:0] d; logic oe;
    bus_wr(2'd0, 8'hA5);
    bus_wr(2'd3, 8'h0F);
    bus_rd(2'd3, d, oe); check("R9 ctrl unchanged", d, 8'h81);
    check("R9 latch A kept", pa_o, 8'hA5);
    check("R9 C oe kept", pc_oe, 8'hF0);
  endtask

  task automatic t_qual;
    logic [7:0] d; logic oe;
    bus_wr(2'd0, 8'h11, 1'b1);        // chip not selected
    check("R3 cs high write", pa_o, 8'hA5);
    bus_wr(2'd0, 8'h22, 1'b0, 1'b0);  // read and write together
    check("R3 rd+wr write", pa_o, 8'hA5);
    bus_wr(2'd3, 8'h9B, 1'b1);
    check("R3 cs high ctrl", pa_oe, 8'hFF);
    @(negedge clk);
    addr = 2'd0; cs_n = 1'b1; rd_n = 1'b0; #1;
    check("R4 cs high read", {7'd0, dout_oe}, 8'h00);
    cs_n = 1'b0; wr_n = 1'b0; #1;
    check("R4 rd+wr", {7'd0, dout_oe}, 8'h00);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    bus_rd(2'd0, d, oe); check("R4 oe valid", {7'd0, oe}, 8'h01);
  endtask

  task automatic t_mode_bits;
    logic [7:0] d; logic oe;
    bus_wr(2'd3, 8'hE4);
    bus_rd(2'd3, d, oe); check("R7 mode field kept", d, 8'hE4);
    check("R5 all out", pa_oe & pb_oe & pc_oe, 8'hFF);
    bus_wr(2'd3, 8'h90);
    check("R5 A in only", pa_oe, 8'h00);
    check("R5 B out", pb_oe, 8'hFF);
  endtask

  initial begin
    #3000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_all_out();
    t_clear();
    t_mixed();
    t_ignored();
    t_qual();
    t_mode_bits();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule